// File: doc/BRIEF.md
# DMA Refill Request Throttle

This block sits between the level logic of a display input FIFO and the DMA engine that refills it. The level logic raises a raw request whenever it wants more words. The throttle counts the words the FIFO accepts. Each time a full burst of sixteen words has been loaded, it holds the outgoing DMA request low for a programmable number of pixel-clock cycles. After that it lets the raw request through again. This spaces out refill bursts so that the shared memory bus is not held by the display path.

The delay is an 8-bit setting, so it ranges from 0 to 255 pixel clocks. A setting of zero adds no pause. The setting is captured when a pause begins, so changing it while a pause runs does not affect that pause. A busy output is high in exactly the cycles in which the request is being suppressed. When the enable input is low, the block clears its counters and passes the raw request straight through.

Top module: `dma_req_throttle`

## Requirements
- R1: After a synchronous reset, the word count and the delay count are zero, busy is 0, and the DMA request equals the raw request.
- R2: A cycle with enable=1 and word_ack=1 counts one accepted word. Words need not arrive in consecutive cycles. The sixteenth counted word completes a burst and restarts the count at zero.
- R3: On the clock edge that counts the sixteenth word, the delay setting present in that cycle is captured as N. busy is then high for exactly the next N cycles.
- R4: In every cycle where busy is 1, dma_req is 0, whatever the value of raw_req.
- R5: If N is 0, busy stays 0 and dma_req follows raw_req in every cycle.
- R6: Changing delay_cfg while busy is 1 does not lengthen or shorten the pause that is already running.
- R7: Words accepted while busy is 1 count toward the next burst of sixteen.
- R8: While enable is 0, busy is 0 and dma_req equals raw_req. On any edge where enable is 0, both counts are cleared, so after enable returns a complete new burst of sixteen words is needed before a pause.
- R9: Outside a pause started by R3, busy is 0 and dma_req equals raw_req combinationally in the same cycle.
- R10: If a burst completes while a pause is running, the pause restarts with the delay setting present on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Throttling enable; low clears state and passes the request through |
| delay_cfg | input | 8 | Pause length in pixel clocks, captured at burst completion |
| word_ack | input | 1 | One word accepted into the FIFO this cycle |
| raw_req | input | 1 | Request from the FIFO level logic |
| dma_req | output | 1 | Gated request to the DMA engine |
| busy | output | 1 | High while the request is suppressed |

## Verification
A wrong word count shows up as a pause that starts too early or too late. The first burst edge that differs from the arithmetic model exposes it, at the latest sixteen accepted words after the fault. A wrong delay count shows up as busy or dma_req differing from the model for at least one cycle at the end of a pause, within 255 cycles of the load. The bench compares both outputs against a modular word count and a decrementing pause model in every cycle. It sweeps every delay value and also covers gapped words, a setting changed mid-pause, bursts completed inside a pause, and enable dropped mid-pause.

// File: rtl/dmat_pkg.sv
package dmat_pkg;
  localparam int unsigned DELAY_W_DEF = 8;
  localparam int unsigned BURST_DEF   = 16;

  // Next word count within a burst: wraps to zero on the last word.
  function automatic int unsigned next_word_count(input int unsigned cur,
                                                  input int unsigned burst);
    return (cur + 1 >= burst) ? 0 : cur + 1;
  endfunction

  // Saturating decrement of the pause counter.
  function automatic int unsigned step_down(input int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction
endpackage

// File: rtl/dmat_word_counter.sv
module dmat_word_counter #(
  parameter int unsigned BURST = 16,
  localparam int unsigned CW = $clog2(BURST + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          wrap
);
  import dmat_pkg::*;

  logic [CW-1:0] count_q;

  assign wrap  = inc && (count_q == CW'(BURST - 1));
  assign count = count_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= CW'(next_word_count(32'(count_q), BURST));
    end
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    count_q < CW'(BURST));

  // R2
  wrap_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && !clr) |=> (count_q == '0));
endmodule

// File: rtl/dmat_delay_counter.sv
module dmat_delay_counter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic [DW-1:0] remain,
  output logic          active
);
  import dmat_pkg::*;

  logic [DW-1:0] remain_q;

  assign remain = remain_q;
  assign active = (remain_q != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (active) begin
      remain_q <= DW'(step_down(32'(remain_q)));
    end
  end

  // R3
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (remain_q == $past(load_val)));

  // R6
  steady_decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !load && !clr) |=> (remain_q == $past(remain_q) - DW'(1)));
endmodule

// File: rtl/dma_req_throttle.sv
module dma_req_throttle #(
  parameter int unsigned DELAY_W = dmat_pkg::DELAY_W_DEF,
  parameter int unsigned BURST   = dmat_pkg::BURST_DEF,
  localparam int unsigned CW = $clog2(BURST + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic [DELAY_W-1:0] delay_cfg,
  input  logic               word_ack,
  input  logic               raw_req,
  output logic               dma_req,
  output logic               busy
);
  // Named internal events, brought out for the assertions.
  logic               word_counted;
  logic               burst_done;
  logic               pause_active;
  logic               hold_clear;
  logic [CW-1:0]      words_in_burst;
  logic [DELAY_W-1:0] pause_left;

  assign hold_clear   = !enable;
  assign word_counted = enable && word_ack;

  dmat_word_counter #(.BURST(BURST)) u_words (
    .clk   (clk),
    .rst   (rst),
    .clr   (hold_clear),
    .inc   (word_counted),
    .count (words_in_burst),
    .wrap  (burst_done)
  );

  dmat_delay_counter #(.DW(DELAY_W)) u_pause (
    .clk      (clk),
    .rst      (rst),
    .clr      (hold_clear),
    .load     (burst_done),
    .load_val (delay_cfg),
    .remain   (pause_left),
    .active   (pause_active)
  );

  assign busy    = enable && pause_active;
  assign dma_req = raw_req && !busy;

  // R8
  disable_clears_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (pause_left == '0) && (words_in_burst == '0));

  // R4
  burst_starts_pause_chk: assert property (@(posedge clk) disable iff (rst)
    (burst_done && (delay_cfg != '0)) |=> (!enable || (busy && !dma_req)));

  // R5
  zero_delay_no_pause_chk: assert property (@(posedge clk) disable iff (rst)
    (burst_done && (delay_cfg == '0)) |=> !busy);
endmodule

// File: tb/dma_req_throttle_test.sv
`timescale 1ns/1ps
module dma_req_throttle_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       enable;
  logic [7:0] delay_cfg;
  logic       word_ack;
  logic       raw_req;
  logic       dma_req;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  int m_words = 0;
  int m_rem   = 0;
  int cycles  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  dma_req_throttle uut (
    .clk(clk), .rst(rst), .enable(enable), .delay_cfg(delay_cfg),
    .word_ack(word_ack), .raw_req(raw_req), .dma_req(dma_req), .busy(busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, compare, advance the model, wait for the next falling edge.
  task automatic tick(input logic en, input logic ack, input logic raw,
                      input logic [7:0] cfg, input string tag);
    logic eb, er;
    enable = en; word_ack = ack; raw_req = raw; delay_cfg = cfg;
    #1;
    eb = en && (m_rem != 0);
    er = raw && !eb;
    check(tag, busy, eb, "busy");
    check(tag, dma_req, er, "dma_req");
    if (!en) begin
      m_words = 0; m_rem = 0;
    end else if (ack && ((m_words + 1) % 16 == 0)) begin
      m_words = 0; m_rem = cfg;
    end else begin
      if (ack) m_words = m_words + 1;
      if (m_rem > 0) m_rem = m_rem - 1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic words(input int n, input logic [7:0] cfg, input string tag);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b1, 1'b1, cfg, tag);
  endtask

  task automatic idle(input int n, input logic raw, input logic [7:0] cfg, input string tag);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b0, raw, cfg, tag);
  endtask

  initial begin
    rst = 1'b1; enable = 1'b0; word_ack = 1'b0; raw_req = 1'b0; delay_cfg = 8'd0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    #1;
    check("R1", busy, 1'b0, "busy after reset");
    check("R1", dma_req, 1'b0, "dma_req after reset");
    raw_req = 1'b1; #1;
    check("R1", dma_req, 1'b1, "dma_req follows raw after reset");
    @(negedge clk);

    // R8: disabled, words do not start a pause
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b1, i[0], 8'd9, "R8");

    // R3 R4 R5 R9: every delay value
    for (int d = 0; d < 256; d++) begin
      words(16, 8'(d), (d == 0) ? "R5" : "R3");
      idle(d + 2, d[0], 8'(d), (d == 0) ? "R5" : "R4");
    end

    // R2: gapped word arrivals
    for (int i = 0; i < 32; i++) tick(1'b1, i[0], 1'b1, 8'd5, "R2");
    for (int i = 0; i < 20; i++) tick(1'b1, (i % 3) == 0, 1'b1, 8'd5, "R2");
    idle(30, 1'b1, 8'd5, "R9");

    // R6: setting changed mid-pause
    words(16, 8'd20, "R6");
    idle(5, 1'b1, 8'd20, "R6");
    idle(10, 1'b1, 8'd3, "R6");
    idle(10, 1'b1, 8'd200, "R6");

    // R7: words inside a pause count toward the next burst
    words(16, 8'd40, "R7");
    words(10, 8'd40, "R7");
    idle(40, 1'b1, 8'd40, "R7");
    words(6, 8'd4, "R7");
    idle(8, 1'b1, 8'd4, "R7");

    // R10: burst completed inside a pause restarts it
    words(16, 8'd60, "R10");
    words(16, 8'd7, "R10");
    idle(12, 1'b1, 8'd7, "R10");
    words(16, 8'd30, "R10");
    words(16, 8'd90, "R10");
    idle(95, 1'b1, 8'd90, "R10");

    // R8: enable dropped mid-pause and with a partial burst
    words(16, 8'd50, "R8");
    idle(5, 1'b1, 8'd50, "R8");
    tick(1'b0, 1'b0, 1'b1, 8'd50, "R8");
    idle(3, 1'b1, 8'd50, "R8");
    words(9, 8'd6, "R8");
    tick(1'b0, 1'b1, 1'b1, 8'd6, "R8");
    words(15, 8'd6, "R8");
    idle(3, 1'b1, 8'd6, "R8");
    words(1, 8'd6, "R8");
    idle(10, 1'b1, 8'd6, "R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule